// File: doc/BRIEF.md
# Authenticated Debug Unlock Sequencer

This block sits next to a boundary-scan TAP and keeps test and debug access closed until an identification exchange of the Schnorr kind succeeds. After a sequence start it drives a fixed series of requests to an external elliptic-curve arithmetic engine. It first derives the device public key from the stored private key. It then draws a nonce from a random source and forms a commitment from it. Once the tester has shifted a 192-bit challenge into a dedicated data register and strobed it in, the block builds the response scalar, recomputes both sides of the verification equation and compares them.

Each engine request is one start pulse carrying an opcode, a base-point select and two 384-bit operand buses (a scalar uses the low half). The sequencer then waits for a done pulse for as long as it takes. The curve parameters, the arithmetic and the random source are outside the block. Only an exact equality of the two final points raises the unlock flag. A TAP reset or a fresh start clears every intermediate value and the verdict.

Top module: `auth_unlock_seq`

## Requirements
- R1: Out of reset, unlock_o, verdict_o, eng_start_o and rng_req_o are all 0.
- R2: The first request after a start is opcode 1 (point multiply) with eng_base_o=1 and the private key zero-extended on eng_a_o. Its 384-bit result is kept as the public key.
- R3: After the public key returns, rng_req_o stays 1 until rng_valid_i is seen. The nonce is latched from rng_data_i, rng_req_o then drops, and the next request is opcode 1 with eng_base_o=1 and the nonce on eng_a_o.
- R4: While dr_shift_i is 1, the challenge register shifts one place toward bit 0 each clock, with tdi_i entering bit 191, and chal_tdo_o shows bit 0. After 192 shifts, the first bit sent sits in bit 0. Once a strobe on dr_update_i is taken, further shifts leave the register unchanged until a restart.
- R5: Each request raises eng_start_o for exactly one cycle. The sequencer waits without limit for eng_done_i, and a done pulse that arrives while no request is outstanding has no effect.
- R6: After the challenge is taken, opcode 2 (modular multiply) is issued with the key and the challenge. Then opcode 3 (modular add) is issued with that product and the nonce, and its result becomes the response s.
- R7: The requests that follow are, in order: opcode 1 with base and s; opcode 1 with eng_base_o=0, the challenge on eng_a_o and the public key on eng_b_o; opcode 4 (point add) with the commitment on eng_a_o and the previous result on eng_b_o.
- R8: Two cycles after the point-add result returns, verdict_o is 1. unlock_o is 1 only if that sum equals the s-times-base result on all 384 bits, and 0 otherwise.
- R9: A one-cycle tap_reset_i clears unlock_o and verdict_o and returns the sequencer to idle. A seq_start_i does the same clearing and restarts the sequence from the public-key request.
- R10: A dr_update_i strobe while the sequencer is idle or finished is ignored. The sequencer then waits for a later strobe and issues no further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tap_reset_i | input | 1 | TAP logic reset, synchronous clear to idle |
| seq_start_i | input | 1 | Clear and start a new exchange |
| tdi_i | input | 1 | Serial challenge data |
| dr_shift_i | input | 1 | Shift enable for the challenge register |
| dr_update_i | input | 1 | Challenge loaded strobe |
| chal_tdo_o | output | 1 | Serial output, bit 0 of the challenge register |
| key_i | input | 192 | Stored private key |
| rng_req_o | output | 1 | Nonce request |
| rng_valid_i | input | 1 | Nonce valid |
| rng_data_i | input | 192 | Nonce value |
| eng_start_o | output | 1 | Engine request pulse |
| eng_op_o | output | 3 | Opcode: 1 point mul, 2 mod mul, 3 mod add, 4 point add |
| eng_base_o | output | 1 | Use the fixed base point as the point operand |
| eng_a_o | output | 384 | Operand A (scalar in low 192 bits) |
| eng_b_o | output | 384 | Operand B (point or scalar) |
| eng_done_i | input | 1 | Engine completion pulse |
| eng_res_i | input | 384 | Engine result (scalar in low 192 bits) |
| unlock_o | output | 1 | Debug access granted |
| verdict_o | output | 1 | Exchange finished |

## Verification
The assertions check several properties on every cycle. Every request pulse lasts a single cycle. The state does not move while a request is outstanding, and the nonce request holds until it is served. The challenge register stays frozen after its strobe, and a strobe taken while inactive does not arm it. The unlock flag never appears without the verdict and only rises on equal points, and both clear after a reset or start. Only the bench scenarios can show the rest. They check the exact order and operand contents of all seven requests against a model built on a toy homomorphic engine stub. They also show that a corrupted engine result turns a match into a refusal, and that a restart in mid-exchange begins again from the public key.

// File: rtl/aus_pkg.sv
package aus_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PUB, S_NONCE, S_COMMIT, S_CHAL, S_MMUL,
    S_MADD, S_SP, S_NBPA, S_PADD, S_CMP, S_DONE
  } seq_st_e;

  localparam logic [2:0] OP_NONE = 3'd0;
  localparam logic [2:0] OP_PMUL = 3'd1;
  localparam logic [2:0] OP_MMUL = 3'd2;
  localparam logic [2:0] OP_MADD = 3'd3;
  localparam logic [2:0] OP_PADD = 3'd4;
endpackage

// File: rtl/aus_chal_sr.sv
module aus_chal_sr #(
  parameter int W = 192
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         active_i,
  input  logic         shift_i,
  input  logic         tdi_i,
  input  logic         update_i,
  output logic [W-1:0] chal_o,
  output logic         ready_o,
  output logic         tdo_o
);
  logic [W-1:0] sr_q;
  logic         frozen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      frozen_q <= 1'b0;
    end else if (clr_i) begin
      sr_q     <= '0;
      frozen_q <= 1'b0;
    end else begin
      if (shift_i && !frozen_q) sr_q <= {tdi_i, sr_q[W-1:1]};
      if (update_i && active_i) frozen_q <= 1'b1;
    end
  end

  assign chal_o  = sr_q;
  assign ready_o = frozen_q;
  assign tdo_o   = sr_q[0];

  p_frozen_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_q && shift_i && !clr_i) |=> $stable(sr_q));
  p_idle_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && !active_i && !frozen_q && !clr_i) |=> !ready_o);
endmodule

// File: rtl/aus_fsm.sv
module aus_fsm
  import aus_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tap_reset_i,
  input  logic     start_i,
  input  logic     rng_valid_i,
  input  logic     chal_ready_i,
  input  logic     eng_done_i,
  output seq_st_e  st_o,
  output logic     cap_o,
  output logic     active_o,
  output logic     rng_req_o,
  output logic     eng_start_o,
  output logic [2:0] eng_op_o,
  output logic     eng_base_o
);
  seq_st_e st_q;
  logic    issued_q;
  logic    is_op;

  function automatic seq_st_e after_op(seq_st_e s);
    case (s)
      S_PUB:    return S_NONCE;
      S_COMMIT: return S_CHAL;
      S_MMUL:   return S_MADD;
      S_MADD:   return S_SP;
      S_SP:     return S_NBPA;
      S_NBPA:   return S_PADD;
      default:  return S_CMP;
    endcase
  endfunction

  assign is_op = (st_q == S_PUB) || (st_q == S_COMMIT) || (st_q == S_MMUL) ||
                 (st_q == S_MADD) || (st_q == S_SP) || (st_q == S_NBPA) ||
                 (st_q == S_PADD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      issued_q <= 1'b0;
    end else if (tap_reset_i) begin
      st_q     <= S_IDLE;
      issued_q <= 1'b0;
    end else if (start_i) begin
      st_q     <= S_PUB;
      issued_q <= 1'b0;
    end else if (is_op) begin
      if (!issued_q) issued_q <= 1'b1;
      else if (eng_done_i) begin
        issued_q <= 1'b0;
        st_q     <= after_op(st_q);
      end
    end else begin
      case (st_q)
        S_NONCE: if (rng_valid_i) st_q <= S_COMMIT;
        S_CHAL:  if (chal_ready_i) st_q <= S_MMUL;
        S_CMP:   st_q <= S_DONE;
        default: st_q <= st_q;
      endcase
    end
  end

  always_comb begin
    eng_op_o   = OP_NONE;
    eng_base_o = 1'b0;
    case (st_q)
      S_PUB, S_COMMIT, S_SP: begin eng_op_o = OP_PMUL; eng_base_o = 1'b1; end
      S_NBPA: eng_op_o = OP_PMUL;
      S_MMUL: eng_op_o = OP_MMUL;
      S_MADD: eng_op_o = OP_MADD;
      S_PADD: eng_op_o = OP_PADD;
      default: ;
    endcase
  end

  assign st_o        = st_q;
  assign eng_start_o = is_op && !issued_q;
  assign cap_o       = is_op && issued_q && eng_done_i;
  assign rng_req_o   = (st_q == S_NONCE);
  assign active_o    = (st_q != S_IDLE) && (st_q != S_DONE);

  p_single_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);
  p_wait_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_op && issued_q && !eng_done_i && !tap_reset_i && !start_i) |=> $stable(st_q));
  p_nonce_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rng_req_o && !rng_valid_i && !tap_reset_i && !start_i) |=> rng_req_o);
  p_reset_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_reset_i |=> (!active_o && !eng_start_o && !rng_req_o));
endmodule

// File: rtl/aus_regs.sv
module aus_regs
  import aus_pkg::*;
#(
  parameter int W  = 192,
  parameter int PW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  seq_st_e       st_i,
  input  logic          cap_i,
  input  logic [W-1:0]  key_i,
  input  logic          rng_valid_i,
  input  logic [W-1:0]  rng_data_i,
  input  logic          chal_ready_i,
  input  logic [W-1:0]  chal_i,
  input  logic [PW-1:0] eng_res_i,
  output logic [PW-1:0] eng_a_o,
  output logic [PW-1:0] eng_b_o,
  output logic          unlock_o,
  output logic          verdict_o
);
  localparam logic [W-1:0] ZW = '0;

  logic [PW-1:0] pa_q, ta_q, sp_q, acc_q;
  logic [W-1:0]  na_q, nb_q, s_q;
  logic          unlock_q, verdict_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q <= '0; ta_q <= '0; sp_q <= '0; acc_q <= '0;
      na_q <= '0; nb_q <= '0; s_q <= '0;
      unlock_q <= 1'b0; verdict_q <= 1'b0;
    end else if (clr_i) begin
      pa_q <= '0; ta_q <= '0; sp_q <= '0; acc_q <= '0;
      na_q <= '0; nb_q <= '0; s_q <= '0;
      unlock_q <= 1'b0; verdict_q <= 1'b0;
    end else begin
      if (cap_i) begin
        case (st_i)
          S_PUB:          pa_q  <= eng_res_i;
          S_COMMIT:       ta_q  <= eng_res_i;
          S_MMUL, S_MADD: s_q   <= eng_res_i[W-1:0];
          S_SP:           sp_q  <= eng_res_i;
          S_NBPA, S_PADD: acc_q <= eng_res_i;
          default: ;
        endcase
      end
      if (st_i == S_NONCE && rng_valid_i) na_q <= rng_data_i;
      if (st_i == S_CHAL && chal_ready_i) nb_q <= chal_i;
      if (st_i == S_CMP) begin
        unlock_q  <= (acc_q == sp_q);
        verdict_q <= 1'b1;
      end
    end
  end

  always_comb begin
    eng_a_o = '0;
    eng_b_o = '0;
    case (st_i)
      S_PUB:    eng_a_o = {ZW, key_i};
      S_COMMIT: eng_a_o = {ZW, na_q};
      S_MMUL:   begin eng_a_o = {ZW, key_i}; eng_b_o = {ZW, nb_q}; end
      S_MADD:   begin eng_a_o = {ZW, s_q};   eng_b_o = {ZW, na_q}; end
      S_SP:     eng_a_o = {ZW, s_q};
      S_NBPA:   begin eng_a_o = {ZW, nb_q};  eng_b_o = pa_q; end
      S_PADD:   begin eng_a_o = ta_q;        eng_b_o = acc_q; end
      default: ;
    endcase
  end

  assign unlock_o  = unlock_q;
  assign verdict_o = verdict_q;

  p_unlock_verdict_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o |-> verdict_o);
  p_unlock_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlock_o) |-> (acc_q == sp_q));
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!unlock_o && !verdict_o));
endmodule

// File: rtl/auth_unlock_seq.sv
module auth_unlock_seq
  import aus_pkg::*;
#(
  parameter int W  = 192,
  parameter int PW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tap_reset_i,
  input  logic          seq_start_i,
  input  logic          tdi_i,
  input  logic          dr_shift_i,
  input  logic          dr_update_i,
  output logic          chal_tdo_o,
  input  logic [W-1:0]  key_i,
  output logic          rng_req_o,
  input  logic          rng_valid_i,
  input  logic [W-1:0]  rng_data_i,
  output logic          eng_start_o,
  output logic [2:0]    eng_op_o,
  output logic          eng_base_o,
  output logic [PW-1:0] eng_a_o,
  output logic [PW-1:0] eng_b_o,
  input  logic          eng_done_i,
  input  logic [PW-1:0] eng_res_i,
  output logic          unlock_o,
  output logic          verdict_o
);
  seq_st_e      st;
  logic         cap, active, chal_ready, clr;
  logic [W-1:0] chal;

  assign clr = tap_reset_i | seq_start_i;

  aus_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tap_reset_i  (tap_reset_i),
    .start_i      (seq_start_i),
    .rng_valid_i  (rng_valid_i),
    .chal_ready_i (chal_ready),
    .eng_done_i   (eng_done_i),
    .st_o         (st),
    .cap_o        (cap),
    .active_o     (active),
    .rng_req_o    (rng_req_o),
    .eng_start_o  (eng_start_o),
    .eng_op_o     (eng_op_o),
    .eng_base_o   (eng_base_o)
  );

  aus_chal_sr #(.W(W)) u_chal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .active_i (active),
    .shift_i  (dr_shift_i),
    .tdi_i    (tdi_i),
    .update_i (dr_update_i),
    .chal_o   (chal),
    .ready_o  (chal_ready),
    .tdo_o    (chal_tdo_o)
  );

  aus_regs #(.W(W), .PW(PW)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .st_i         (st),
    .cap_i        (cap),
    .key_i        (key_i),
    .rng_valid_i  (rng_valid_i),
    .rng_data_i   (rng_data_i),
    .chal_ready_i (chal_ready),
    .chal_i       (chal),
    .eng_res_i    (eng_res_i),
    .eng_a_o      (eng_a_o),
    .eng_b_o      (eng_b_o),
    .unlock_o     (unlock_o),
    .verdict_o    (verdict_o)
  );
endmodule

// File: tb/auth_unlock_seq_tb.sv
module auth_unlock_seq_tb;
  localparam int W  = 192;
  localparam int PW = 2 * W;
  localparam logic [W-1:0] G = 192'h6a09e667f3bcc908b2fb1366ea957d3e3adec17512775099;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tap_reset_i = 1'b0, seq_start_i = 1'b0;
  logic tdi_i = 1'b0, dr_shift_i = 1'b0, dr_update_i = 1'b0;
  logic chal_tdo_o;
  logic [W-1:0] key_i = '0;
  logic rng_req_o, rng_valid_i = 1'b0;
  logic [W-1:0] rng_data_i = '0;
  logic eng_start_o, eng_base_o;
  logic [2:0] eng_op_o;
  logic [PW-1:0] eng_a_o, eng_b_o;
  logic eng_done_i;
  logic [PW-1:0] eng_res_i = '0;
  logic unlock_o, verdict_o;

  logic stub_done = 1'b0, spur_done = 1'b0;
  assign eng_done_i = stub_done | spur_done;

  always #5 clk_i = ~clk_i;

  auth_unlock_seq u_dut (.*);

  int n_cmp = 0, n_bad = 0;
  int idx = 0;
  logic fault = 1'b0;
  logic [W-1:0] m_key, m_na, m_nb;

  function automatic logic [PW-1:0] pm(logic [W-1:0] k, logic [W-1:0] px);
    logic [W-1:0] x;
    x = k * px;
    return {~x, x};
  endfunction

  function automatic logic [PW-1:0] padd(logic [PW-1:0] a, logic [PW-1:0] b);
    logic [W-1:0] x;
    x = a[W-1:0] + b[W-1:0];
    return {~x, x};
  endfunction

  task automatic chk(string req, string what, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // engine stub and per-request reference compare
  always @(negedge clk_i) begin
    logic [2:0] e_op;
    logic e_base;
    logic [PW-1:0] e_a, e_b, r;
    logic [W-1:0] s_m;
    int cnt_l;
    string rq;
    if (stub_done) stub_done = 1'b0;
    if (seq_start_i || tap_reset_i) idx = 0;
    if (cnt_l > 0) begin
      cnt_l--;
      if (cnt_l == 0) stub_done = 1'b1;
    end
    if (eng_start_o) begin
      s_m = m_key * m_nb + m_na;
      e_a = '0; e_b = '0; e_base = 1'b0;
      case (idx)
        0: begin rq = "R2"; e_op = 3'd1; e_base = 1'b1; e_a = {{W{1'b0}}, m_key}; end
        1: begin rq = "R3"; e_op = 3'd1; e_base = 1'b1; e_a = {{W{1'b0}}, m_na}; end
        2: begin rq = "R6"; e_op = 3'd2; e_a = {{W{1'b0}}, m_key}; e_b = {{W{1'b0}}, m_nb}; end
        3: begin rq = "R6"; e_op = 3'd3; e_a = {{W{1'b0}}, W'(m_key * m_nb)}; e_b = {{W{1'b0}}, m_na}; end
        4: begin rq = "R7"; e_op = 3'd1; e_base = 1'b1; e_a = {{W{1'b0}}, s_m}; end
        5: begin rq = "R7"; e_op = 3'd1; e_a = {{W{1'b0}}, m_nb}; e_b = pm(m_key, G); end
        default: begin rq = "R7"; e_op = 3'd4; e_a = pm(m_na, G); e_b = pm(m_nb, pm(m_key, G)); end
      endcase
      chk(rq, "req op", PW'(eng_op_o), PW'(e_op));
      chk(rq, "req base", PW'(eng_base_o), PW'(e_base));
      chk(rq, "req a", eng_a_o, e_a);
      chk(rq, "req b", eng_b_o, e_b);
      case (eng_op_o)
        3'd1: r = pm(eng_a_o[W-1:0], eng_base_o ? G : eng_b_o[W-1:0]);
        3'd2: r = {{W{1'b0}}, W'(eng_a_o[W-1:0] * eng_b_o[W-1:0])};
        3'd3: r = {{W{1'b0}}, W'(eng_a_o[W-1:0] + eng_b_o[W-1:0])};
        default: r = padd(eng_a_o, eng_b_o) ^ {{(PW-1){1'b0}}, fault};
      endcase
      eng_res_i = r;
      cnt_l = 1 + (idx * 3) % 7;
      idx++;
    end
  end

  task automatic tick(); @(posedge clk_i); #2; endtask
  task automatic sample(); @(negedge clk_i); #1; endtask

  task automatic pulse_start();
    tick(); seq_start_i = 1'b1; tick(); seq_start_i = 1'b0;
  endtask

  task automatic give_nonce(logic [W-1:0] v, int hold);
    while (!rng_req_o) sample();
    for (int i = 0; i < hold; i++) begin
      sample();
      chk("R3", "rng_req held", PW'(rng_req_o), PW'(1));
    end
    tick(); rng_valid_i = 1'b1; rng_data_i = v;
    tick(); rng_valid_i = 1'b0;
    sample();
    chk("R3", "rng_req dropped", PW'(rng_req_o), PW'(0));
  endtask

  task automatic shift_in(logic [W-1:0] v);
    for (int i = 0; i < W; i++) begin
      tick(); dr_shift_i = 1'b1; tdi_i = v[i];
    end
    tick(); dr_shift_i = 1'b0;
  endtask

  task automatic strobe();
    tick(); dr_update_i = 1'b1; tick(); dr_update_i = 1'b0;
  endtask

  task automatic wait_verdict();
    for (int i = 0; i < 3000 && !verdict_o; i++) sample();
    chk("R8", "verdict", PW'(verdict_o), PW'(1));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    sample();
    // R1 reset state
    chk("R1", "unlock", PW'(unlock_o), PW'(0));
    chk("R1", "verdict", PW'(verdict_o), PW'(0));
    chk("R1", "eng_start", PW'(eng_start_o), PW'(0));
    chk("R1", "rng_req", PW'(rng_req_o), PW'(0));

    // run 1: honest engine, idle strobe ignored, spurious done, extra shifts
    m_key = 192'h1f2e3d4c5b6a79880123456789abcdeffedcba9876543210;
    m_na  = 192'h0badc0ffee0ddf00d5eed1234567890aabbccddeeff00112;
    m_nb  = 192'h5555aaaa3333cccc0f0f0f0ff0f0f0f0123456789abcdef1;
    key_i = m_key;
    strobe();                                   // R10 idle strobe
    pulse_start();
    give_nonce(m_na, 5);
    repeat (40) sample();
    chk("R10", "stalled before challenge", PW'(idx), PW'(2));
    chk("R10", "no start while waiting", PW'(eng_start_o), PW'(0));
    tick(); spur_done = 1'b1; tick(); spur_done = 1'b0;   // R5 stray done
    repeat (5) sample();
    chk("R5", "stray done ignored", PW'(idx), PW'(2));
    shift_in(m_nb);
    sample();
    chk("R4", "tdo after full shift", PW'(chal_tdo_o), PW'(m_nb[0]));
    strobe();
    for (int i = 0; i < 8; i++) begin
      tick(); dr_shift_i = 1'b1; tdi_i = ~m_nb[0];
    end
    tick(); dr_shift_i = 1'b0;
    sample();
    chk("R4", "shift after strobe ignored", PW'(chal_tdo_o), PW'(m_nb[0]));
    wait_verdict();
    chk("R8", "unlock on match", PW'(unlock_o), PW'(1));
    chk("R7", "request count", PW'(idx), PW'(7));

    // run 2: corrupted point sum -> refusal
    fault = 1'b1;
    m_na = 192'h00000000000000000000000000000000000000000000beef;
    m_nb = 192'hffffffffffffffffffffffffffffffffffffffffffffffff;
    pulse_start();
    sample();
    chk("R9", "start clears unlock", PW'(unlock_o), PW'(0));
    chk("R9", "start clears verdict", PW'(verdict_o), PW'(0));
    give_nonce(m_na, 0);
    shift_in(m_nb);
    strobe();
    wait_verdict();
    chk("R8", "no unlock on mismatch", PW'(unlock_o), PW'(0));

    // run 3: restart in the challenge wait, then honest finish, then TAP reset
    fault = 1'b0;
    m_key = 192'h0000000000000000000000000000000000000000000000003;
    key_i = m_key;
    m_na  = 192'h7;
    pulse_start();
    give_nonce(m_na, 2);
    while (idx < 2) sample();
    repeat (10) sample();
    m_na = 192'h123456789;
    m_nb = 192'h800000000000000000000000000000000000000000000001;
    pulse_start();                              // R9 restart from public key
    give_nonce(m_na, 1);
    shift_in(m_nb);
    strobe();
    wait_verdict();
    chk("R8", "unlock after restart", PW'(unlock_o), PW'(1));
    tick(); tap_reset_i = 1'b1; tick(); tap_reset_i = 1'b0;
    sample();
    chk("R9", "tap reset clears unlock", PW'(unlock_o), PW'(0));
    chk("R9", "tap reset clears verdict", PW'(verdict_o), PW'(0));
    repeat (5) sample();
    chk("R9", "idle after tap reset", PW'(eng_start_o | rng_req_o), PW'(0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule